// File: doc/BRIEF.md
# Parser Lookup Key Builder

This block assembles the two lookup keys one parse step needs, working from a snapshot of the parser state. The first is a 20-byte probe key for the boost match stage. It takes the packet bytes that follow the current header offset, in reverse order, and tops them with a selector byte. The second is the set of parse-graph key fields: the current node number, up to four flag bits picked from a 64-bit flag vector, the value of one chosen register, a group index from the boost stage, and a 32-bit next-protocol value.

The next-protocol value comes from one of four sources. It can be a bit window cut from the header vector, two registers placed side by side, a constant zero, or all ones for an unsupported code. The header-vector window follows network bit order: each byte is read most significant bit first, and the lower-addressed byte comes first.

The caller sets the instruction fields, places the packet byte window and register views on the inputs, and pulses `start`. All key outputs are captured on that edge, and `key_vld` is high for the following cycle. The outputs then hold until the next pulse. The match tables that consume the keys sit outside this block.

Top module: `lookup_key_builder`

## Requirements
- R1: Key byte 19 (bits 159:152 of `bkey`) equals `tsr_val` when `tsr_sel` is 1, and `prio_val` when `tsr_sel` is 0.
- R2: Key byte i, for i from 0 to 18 (bits 8i+7:8i), equals window byte 18−i (`pkt_win` bits 8(18−i)+7:8(18−i)). Window byte k is the packet byte at position `hdr_ofs`+k.
- R3: Any key byte i in 0..18 whose packet position `hdr_ofs`+18−i is 504 or more reads as zero.
- R4: `np_op` selects the next-protocol source. Code 0 is the header-vector window. Code 1 places register `np_a` in bits 15:0 and register `np_b` in bits 31:16. Code 2 gives zero. Code 3 gives 32'hFFFFFFFF.
- R5: For code 0, the header vector is treated as a bit stream: byte 2w is `hv` word w bits 7:0, byte 2w+1 is word w bits 15:8, and each byte is read MSB first. Starting at stream bit `np_a`, `np_b` bits are taken, and the first bit taken becomes the result MSB. A length of 0 gives 0, a length above 32 is treated as 32, and stream bits past the last header-vector word read as zero.
- R6: Output flag k (bit k of `pg_flags`) equals `flag_vec[flag_idx slot k]` when `flag_en[k]` is 1, and 0 otherwise. Slot k is `flag_idx` bits 6k+5:6k, and flag n sits in word n/16 at bit n mod 16, which is `flag_vec[n]`.
- R7: `pg_node` equals register 1 of `regs`, and `pg_alu` equals register `alu_sel`. Register r is `regs` bits 16r+15:16r.
- R8: `pg_grp` equals `boost_grp` when `from_boost` is 1, and is zero otherwise.
- R9: `key_vld` is high exactly in the cycle after a cycle with `start` high. All key outputs change only on a `start` edge.
- R10: While `rst_n` is low, `key_vld` and every key output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe for one parse step |
| hdr_ofs | input | 10 | Current header offset in bytes |
| tsr_sel | input | 1 | Selects the TSR byte for key byte 19 |
| tsr_val | input | 8 | TSR register byte |
| prio_val | input | 8 | Instruction priority byte |
| pkt_win | input | 152 | 19 packet bytes starting at the header offset |
| regs | input | 256 | Register file view, 16 registers of 16 bits |
| hv | input | 128 | Header vector, 8 words of 16 bits |
| flag_vec | input | 64 | Parser flag vector |
| np_op | input | 2 | Next-protocol source code |
| np_a | input | 7 | Window start bit, or low register index |
| np_b | input | 6 | Window length, or high register index |
| flag_en | input | 4 | Enables for the four key flags |
| flag_idx | input | 24 | Four 6-bit flag indices |
| alu_sel | input | 4 | Register index for the ALU value field |
| from_boost | input | 1 | Key originates from a boost hit |
| boost_grp | input | 8 | Group index of the boost hit |
| bkey | output | 160 | Probe key, byte i at bits 8i+7:8i |
| pg_node | output | 16 | Node number field |
| pg_flags | output | 4 | Four key flags |
| pg_alu | output | 16 | Selected register value |
| pg_np | output | 32 | Next-protocol value |
| pg_grp | output | 8 | Boost group index |
| key_vld | output | 1 | Keys valid, one cycle after start |

## Verification
The bench uses the default parameters: a 10-bit offset, a 504-byte packet limit, 16 registers, an 8-word header vector and 64 flags. The 10-bit offset can point at and beyond the limit, so the bench can check the partial zero fill at offset 490 and the full fill at 504. The 8-word header vector is small enough that a window starting in the last word runs off the end, so the zero padding past the vector is checked as well. Lengths of 0, 1, 32 and 40 cover both mask limits and the saturation at 32.

// File: rtl/lkb_pkg.sv
package lkb_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      NP_HDRVEC  = 2'd0,
      NP_REGPAIR = 2'd1,
      NP_ZERO    = 2'd2,
      NP_BAD     = 2'd3
   } np_src_e;
endpackage

// File: rtl/lkb_hv_window.sv
// Cuts a field out of the header vector in network bit order.
module lkb_hv_window
   import lkb_pkg::*;
#(
   parameter int HV_WORDS = 8,
   parameter int SEL_W    = 7,
   parameter int LEN_W    = 6,
   parameter int OUT_W    = 32
) (
   input  logic [HV_WORDS*WORD_W-1:0] hv,
   input  logic [SEL_W-1:0]           start,
   input  logic [LEN_W-1:0]           len,
   output logic [OUT_W-1:0]           field
);
   localparam int GRAB_WORDS = 4;
   localparam int GRAB_BITS  = GRAB_WORDS * WORD_W;

   if (SEL_W < 4) begin : g_bad_sel
      $error("lkb_hv_window: SEL_W must cover a word bit offset");
   end
   if (OUT_W + WORD_W - 1 > GRAB_BITS) begin : g_bad_out
      $error("lkb_hv_window: OUT_W too wide for the grab window");
   end

   logic [GRAB_BITS-1:0] grab;
   logic [GRAB_BITS-1:0] stream;
   logic [GRAB_BITS-1:0] shifted;
   int                   base;
   int                   len_eff;

   always_comb begin
      base = int'(start) / WORD_W;
      grab = '0;
      for (int k = 0; k < GRAB_WORDS; k++) begin
         for (int w = 0; w < HV_WORDS; w++) begin
            if (w == base + k) grab[k*WORD_W +: WORD_W] = hv[w*WORD_W +: WORD_W];
         end
      end
      // per byte bit reversal: stream bit 0 is the byte MSB
      for (int b = 0; b < GRAB_BITS / BYTE_W; b++) begin
         for (int j = 0; j < BYTE_W; j++) begin
            stream[b*BYTE_W + j] = grab[b*BYTE_W + BYTE_W - 1 - j];
         end
      end
      shifted = stream >> start[3:0];
      len_eff = (int'(len) > OUT_W) ? OUT_W : int'(len);
      field   = '0;
      for (int i = 0; i < OUT_W; i++) begin
         if (i < len_eff) field[i] = shifted[len_eff - 1 - i];
      end
   end
endmodule

// File: rtl/lkb_np_select.sv
// Chooses the next-protocol key source.
module lkb_np_select
   import lkb_pkg::*;
#(
   parameter int HV_WORDS = 8,
   parameter int NUM_REGS = 16,
   parameter int SEL_W    = 7,
   parameter int LEN_W    = 6,
   parameter int NP_W     = 32
) (
   input  logic [1:0]                 np_op,
   input  logic [SEL_W-1:0]           np_a,
   input  logic [LEN_W-1:0]           np_b,
   input  logic [NUM_REGS*WORD_W-1:0] regs,
   input  logic [HV_WORDS*WORD_W-1:0] hv,
   output logic [NP_W-1:0]            np_val
);
   localparam int REG_IW = $clog2(NUM_REGS);

   if (NP_W != 2 * WORD_W) begin : g_bad_np
      $error("lkb_np_select: NP_W must hold two register words");
   end
   if (SEL_W < REG_IW || LEN_W < REG_IW) begin : g_bad_idx
      $error("lkb_np_select: operand fields narrower than register index");
   end

   logic [NP_W-1:0]   win_val;
   logic [WORD_W-1:0] lo_reg;
   logic [WORD_W-1:0] hi_reg;

   lkb_hv_window #(
      .HV_WORDS (HV_WORDS),
      .SEL_W    (SEL_W),
      .LEN_W    (LEN_W),
      .OUT_W    (NP_W)
   ) u_win (
      .hv    (hv),
      .start (np_a),
      .len   (np_b),
      .field (win_val)
   );

   assign lo_reg = regs[np_a[REG_IW-1:0]*WORD_W +: WORD_W];
   assign hi_reg = regs[np_b[REG_IW-1:0]*WORD_W +: WORD_W];

   always_comb begin
      case (np_src_e'(np_op))
         NP_HDRVEC:  np_val = win_val;
         NP_REGPAIR: np_val = {hi_reg, lo_reg};
         NP_ZERO:    np_val = '0;
         default:    np_val = '1;
      endcase
   end
endmodule

// File: rtl/lkb_probe_key.sv
// Forms the byte-reversed probe key with zero fill past the packet limit.
module lkb_probe_key
   import lkb_pkg::*;
#(
   parameter int PROBE_BYTES = 19,
   parameter int OFS_W       = 10,
   parameter int PKT_LIMIT   = 504
) (
   input  logic [OFS_W-1:0]              hdr_ofs,
   input  logic [PROBE_BYTES*BYTE_W-1:0] pkt_win,
   input  logic                          tsr_sel,
   input  logic [BYTE_W-1:0]             tsr_val,
   input  logic [BYTE_W-1:0]             prio_val,
   output logic [(PROBE_BYTES+1)*BYTE_W-1:0] key
);
   localparam int          PW  = OFS_W + 1;
   localparam logic [PW-1:0] LIM = PW'(PKT_LIMIT);

   if (PKT_LIMIT >= (1 << PW) || PROBE_BYTES >= (1 << OFS_W)) begin : g_bad_lim
      $error("lkb_probe_key: limit or key length exceeds offset range");
   end

   for (genvar i = 0; i < PROBE_BYTES; i++) begin : g_byte
      localparam int DIST = PROBE_BYTES - 1 - i;
      logic [PW-1:0] pos;
      assign pos = {1'b0, hdr_ofs} + PW'(DIST);
      assign key[i*BYTE_W +: BYTE_W] = (pos < LIM) ? pkt_win[DIST*BYTE_W +: BYTE_W] : '0;
   end

   assign key[PROBE_BYTES*BYTE_W +: BYTE_W] = tsr_sel ? tsr_val : prio_val;
endmodule

// File: rtl/lkb_flag_tap.sv
// Picks one enabled flag from the flag vector.
module lkb_flag_tap #(
   parameter int FLAG_BITS = 64,
   parameter int IDX_W     = 6
) (
   input  logic [FLAG_BITS-1:0] flags,
   input  logic                 en,
   input  logic [IDX_W-1:0]     idx,
   output logic                 bit_o
);
   if ((1 << IDX_W) != FLAG_BITS) begin : g_bad_flags
      $error("lkb_flag_tap: FLAG_BITS must be 2**IDX_W");
   end

   assign bit_o = en & flags[idx];
endmodule

// File: rtl/lookup_key_builder.sv
module lookup_key_builder
   import lkb_pkg::*;
#(
   parameter int OFS_W         = 10,
   parameter int PKT_LIMIT     = 504,
   parameter int PROBE_BYTES   = 19,
   parameter int HV_WORDS      = 8,
   parameter int NUM_REGS      = 16,
   parameter int NODE_REG      = 1,
   parameter int FLAG_BITS     = 64,
   parameter int NUM_FLAG_KEYS = 4,
   parameter int LEN_W         = 6,
   parameter int NP_W          = 32,
   parameter int GRP_W         = 8,
   localparam int KEY_W        = (PROBE_BYTES + 1) * 8,
   localparam int SEL_W        = $clog2(HV_WORDS * 16),
   localparam int REG_IW       = $clog2(NUM_REGS),
   localparam int FLAG_IW      = $clog2(FLAG_BITS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [OFS_W-1:0]              hdr_ofs,
   input  logic                          tsr_sel,
   input  logic [7:0]                    tsr_val,
   input  logic [7:0]                    prio_val,
   input  logic [PROBE_BYTES*8-1:0]      pkt_win,
   input  logic [NUM_REGS*16-1:0]        regs,
   input  logic [HV_WORDS*16-1:0]        hv,
   input  logic [FLAG_BITS-1:0]          flag_vec,
   input  logic [1:0]                    np_op,
   input  logic [SEL_W-1:0]              np_a,
   input  logic [LEN_W-1:0]              np_b,
   input  logic [NUM_FLAG_KEYS-1:0]      flag_en,
   input  logic [NUM_FLAG_KEYS*FLAG_IW-1:0] flag_idx,
   input  logic [REG_IW-1:0]             alu_sel,
   input  logic                          from_boost,
   input  logic [GRP_W-1:0]              boost_grp,
   output logic [KEY_W-1:0]              bkey,
   output logic [15:0]                   pg_node,
   output logic [NUM_FLAG_KEYS-1:0]      pg_flags,
   output logic [15:0]                   pg_alu,
   output logic [NP_W-1:0]               pg_np,
   output logic [GRP_W-1:0]              pg_grp,
   output logic                          key_vld
);
   if ((1 << REG_IW) != NUM_REGS) begin : g_bad_regs
      $error("lookup_key_builder: NUM_REGS must be a power of two");
   end
   if (NODE_REG >= NUM_REGS) begin : g_bad_node
      $error("lookup_key_builder: NODE_REG outside the register file");
   end
   if (NUM_FLAG_KEYS < 1) begin : g_bad_nflags
      $error("lookup_key_builder: at least one key flag required");
   end

   logic [KEY_W-1:0]         key_n;
   logic [NP_W-1:0]          np_n;
   logic [NUM_FLAG_KEYS-1:0] flags_n;
   logic [WORD_W-1:0]        node_n;
   logic [WORD_W-1:0]        alu_n;
   logic [GRP_W-1:0]         grp_n;

   lkb_probe_key #(
      .PROBE_BYTES (PROBE_BYTES),
      .OFS_W       (OFS_W),
      .PKT_LIMIT   (PKT_LIMIT)
   ) u_probe (
      .hdr_ofs  (hdr_ofs),
      .pkt_win  (pkt_win),
      .tsr_sel  (tsr_sel),
      .tsr_val  (tsr_val),
      .prio_val (prio_val),
      .key      (key_n)
   );

   lkb_np_select #(
      .HV_WORDS (HV_WORDS),
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W),
      .LEN_W    (LEN_W),
      .NP_W     (NP_W)
   ) u_np (
      .np_op  (np_op),
      .np_a   (np_a),
      .np_b   (np_b),
      .regs   (regs),
      .hv     (hv),
      .np_val (np_n)
   );

   for (genvar k = 0; k < NUM_FLAG_KEYS; k++) begin : g_flag
      lkb_flag_tap #(
         .FLAG_BITS (FLAG_BITS),
         .IDX_W     (FLAG_IW)
      ) u_tap (
         .flags (flag_vec),
         .en    (flag_en[k]),
         .idx   (flag_idx[k*FLAG_IW +: FLAG_IW]),
         .bit_o (flags_n[k])
      );
   end

   assign node_n = regs[NODE_REG*WORD_W +: WORD_W];
   assign alu_n  = regs[alu_sel*WORD_W +: WORD_W];
   assign grp_n  = from_boost ? boost_grp : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bkey     <= '0;
         pg_node  <= '0;
         pg_flags <= '0;
         pg_alu   <= '0;
         pg_np    <= '0;
         pg_grp   <= '0;
         key_vld  <= 1'b0;
      end else begin
         key_vld <= start;
         if (start) begin
            bkey     <= key_n;
            pg_node  <= node_n;
            pg_flags <= flags_n;
            pg_alu   <= alu_n;
            pg_np    <= np_n;
            pg_grp   <= grp_n;
         end
      end
   end
endmodule

// File: rtl/lkb_checker.sv
module lkb_checker #(
   parameter int OFS_W         = 10,
   parameter int PKT_LIMIT     = 504,
   parameter int KEY_W         = 160,
   parameter int NP_W          = 32,
   parameter int GRP_W         = 8,
   parameter int NUM_FLAG_KEYS = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic [OFS_W-1:0]         hdr_ofs,
   input logic                     tsr_sel,
   input logic [7:0]               tsr_val,
   input logic [7:0]               prio_val,
   input logic [1:0]               np_op,
   input logic [NUM_FLAG_KEYS-1:0] flag_en,
   input logic                     from_boost,
   input logic [KEY_W-1:0]         bkey,
   input logic [NUM_FLAG_KEYS-1:0] pg_flags,
   input logic [NP_W-1:0]          pg_np,
   input logic [GRP_W-1:0]         pg_grp,
   input logic                     key_vld
);
   localparam logic [OFS_W:0] LIM = (OFS_W + 1)'(PKT_LIMIT);

   AST_VLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> key_vld); // R9
   AST_VLD_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> $past(start)); // R9
   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(bkey) && $stable(pg_np) && $stable(pg_grp))); // R9
   AST_SEL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> (bkey[KEY_W-1 -: 8] == ($past(tsr_sel) ? $past(tsr_val) : $past(prio_val)))); // R1
   AST_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && ({1'b0, $past(hdr_ofs)} >= LIM)) |-> (bkey[KEY_W-9:0] == '0)); // R3
   AST_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && $past(np_op) == 2'd2) |-> (pg_np == '0)); // R4
   AST_OP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && $past(np_op) == 2'd3) |-> (pg_np == '1)); // R4
   AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> ((pg_flags & ~$past(flag_en)) == '0)); // R6
   AST_GRP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && !$past(from_boost)) |-> (pg_grp == '0)); // R8
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (!key_vld && pg_np == '0)); // R10
endmodule

bind lookup_key_builder lkb_checker #(
   .OFS_W         (OFS_W),
   .PKT_LIMIT     (PKT_LIMIT),
   .KEY_W         (KEY_W),
   .NP_W          (NP_W),
   .GRP_W         (GRP_W),
   .NUM_FLAG_KEYS (NUM_FLAG_KEYS)
) u_lkb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .hdr_ofs    (hdr_ofs),
   .tsr_sel    (tsr_sel),
   .tsr_val    (tsr_val),
   .prio_val   (prio_val),
   .np_op      (np_op),
   .flag_en    (flag_en),
   .from_boost (from_boost),
   .bkey       (bkey),
   .pg_flags   (pg_flags),
   .pg_np      (pg_np),
   .pg_grp     (pg_grp),
   .key_vld    (key_vld)
);

// File: tb/lookup_key_builder_bench.sv
module lookup_key_builder_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [9:0]   hdr_ofs = '0;
   logic         tsr_sel = 1'b0;
   logic [7:0]   tsr_val = '0;
   logic [7:0]   prio_val = '0;
   logic [151:0] pkt_win = '0;
   logic [255:0] regs = '0;
   logic [127:0] hv = '0;
   logic [63:0]  flag_vec = '0;
   logic [1:0]   np_op = '0;
   logic [6:0]   np_a = '0;
   logic [5:0]   np_b = '0;
   logic [3:0]   flag_en = '0;
   logic [23:0]  flag_idx = '0;
   logic [3:0]   alu_sel = '0;
   logic         from_boost = 1'b0;
   logic [7:0]   boost_grp = '0;
   logic [159:0] bkey;
   logic [15:0]  pg_node;
   logic [3:0]   pg_flags;
   logic [15:0]  pg_alu;
   logic [31:0]  pg_np;
   logic [7:0]   pg_grp;
   logic         key_vld;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lookup_key_builder u_lookup_key_builder (
      .clk(clk), .rst_n(rst_n), .start(start), .hdr_ofs(hdr_ofs),
      .tsr_sel(tsr_sel), .tsr_val(tsr_val), .prio_val(prio_val),
      .pkt_win(pkt_win), .regs(regs), .hv(hv), .flag_vec(flag_vec),
      .np_op(np_op), .np_a(np_a), .np_b(np_b), .flag_en(flag_en),
      .flag_idx(flag_idx), .alu_sel(alu_sel), .from_boost(from_boost),
      .boost_grp(boost_grp), .bkey(bkey), .pg_node(pg_node),
      .pg_flags(pg_flags), .pg_alu(pg_alu), .pg_np(pg_np),
      .pg_grp(pg_grp), .key_vld(key_vld)
   );

   // {np_op, np_a (start / low reg), np_b (length / high reg), expected}
   localparam logic [46:0] NP_VEC [12] = '{
      {2'd0, 7'd0,   6'd16, 32'h0000_1234},
      {2'd0, 7'd4,   6'd8,  32'h0000_0023},
      {2'd0, 7'd8,   6'd16, 32'h0000_3456},
      {2'd0, 7'd16,  6'd32, 32'h5678_9ABC},
      {2'd0, 7'd20,  6'd12, 32'h0000_0678},
      {2'd0, 7'd3,   6'd1,  32'h0000_0001},
      {2'd0, 7'd0,   6'd0,  32'h0000_0000},
      {2'd0, 7'd120, 6'd16, 32'h0000_CD00},
      {2'd0, 7'd0,   6'd40, 32'h1234_5678},
      {2'd1, 7'd3,   6'd5,  32'h0F05_0F03},
      {2'd2, 7'd9,   6'd9,  32'h0000_0000},
      {2'd3, 7'd0,   6'd0,  32'hFFFF_FFFF}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fire();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      hv = {16'hCDAB, 16'h0000, 16'h0000, 16'h0000,
            16'hF0DE, 16'hBC9A, 16'h7856, 16'h3412};
      for (int i = 0; i < 16; i++) regs[i*16 +: 16] = 16'h0F00 + 16'(i);
      for (int k = 0; k < 19; k++) pkt_win[k*8 +: 8] = 8'h40 + 8'(k);
      tsr_val  = 8'h77;
      prio_val = 8'h11;

      // R10: reset state
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      check("R10 key_vld", 32'(key_vld), 32'h0);
      check("R10 pg_np", pg_np, 32'h0);
      check("R10 bkey", bkey[31:0], 32'h0);
      check("R10 pg_node", 32'(pg_node), 32'h0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R5: table of next-protocol sources
      for (int r = 0; r < 12; r++) begin
         np_op = NP_VEC[r][46:45];
         np_a  = NP_VEC[r][44:38];
         np_b  = NP_VEC[r][37:32];
         fire();
         check((np_op == 2'd0) ? "R5 window" : "R4 source", pg_np, NP_VEC[r][31:0]);
         check("R9 valid after start", 32'(key_vld), 32'h1);
      end

      // R9: outputs hold without start, valid drops
      np_op   = 2'd2;
      hdr_ofs = 10'd600;
      @(negedge clk);
      @(negedge clk);
      check("R9 hold np", pg_np, 32'hFFFF_FFFF);
      check("R9 valid low", 32'(key_vld), 32'h0);

      // R1 / R2: probe key at offset 0 with TSR select
      hdr_ofs = 10'd0;
      tsr_sel = 1'b1;
      fire();
      check("R1 tsr byte", 32'(bkey[159:152]), 32'h77);
      check("R2 byte0", 32'(bkey[7:0]), 32'h52);
      check("R2 byte18", 32'(bkey[151:144]), 32'h40);
      check("R2 byte7", 32'(bkey[63:56]), 32'h4B);

      // R3: partial zero fill near the limit
      hdr_ofs = 10'd490;
      tsr_sel = 1'b0;
      fire();
      check("R1 prio byte", 32'(bkey[159:152]), 32'h11);
      check("R3 byte4 zero", 32'(bkey[39:32]), 32'h0);
      check("R3 byte0 zero", 32'(bkey[7:0]), 32'h0);
      check("R2 byte5 last", 32'(bkey[47:40]), 32'h4D);

      hdr_ofs = 10'd504;
      fire();
      check("R3 byte18 zero", 32'(bkey[151:144]), 32'h0);

      // R6: flags
      flag_vec = 64'h8000_0001_0000_0004;
      flag_idx = {6'd32, 6'd3, 6'd63, 6'd2};
      flag_en  = 4'b0111;
      fire();
      check("R6 flags", 32'(pg_flags), 32'h3);
      flag_en = 4'b1000;
      fire();
      check("R6 flags slot3", 32'(pg_flags), 32'h8);

      // R7: node and ALU register
      alu_sel = 4'd7;
      fire();
      check("R7 node", 32'(pg_node), 32'h0F01);
      check("R7 alu", 32'(pg_alu), 32'h0F07);

      // R8: group index
      from_boost = 1'b1;
      boost_grp  = 8'h5A;
      fire();
      check("R8 boost grp", 32'(pg_grp), 32'h5A);
      from_boost = 1'b0;
      fire();
      check("R8 local grp", 32'(pg_grp), 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule